// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the front of an Ethernet receive path and decides, from the first six bytes of a frame, whether the frame is wanted. Bytes arrive one per qualified cycle, with a start marker on the first byte. The block assembles the 48-bit destination address and updates a running CRC-32 over it as the bytes arrive. As soon as the sixth byte is taken it issues a single verdict: keep the frame or drop it. Bytes after the address are ignored.

Four sources can make a frame acceptable:

- an exact match with the programmed station address;
- the all-ones broadcast address, when broadcast reception is enabled;
- a promiscuous enable, which admits everything;
- a 64-bin hash table indexed by six CRC bits of the address.

The hash is consulted for group addresses. An optional individual-hash mode also consults it for unicast addresses that miss the station address.

Configuration comes from static register fields that the receive path's control logic keeps stable while an address is being received. If a frame ends before its sixth byte, it is reported as rejected.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, `verdict_valid` and `verdict_accept` are low. No verdict appears until either six address bytes have been taken or a frame has ended early.
- R2: A byte with `in_valid` and `in_sof` both high is taken as address byte 0. This abandons any address in progress without a verdict for it.
- R3: `verdict_valid` pulses high for exactly one cycle, starting right after the clock edge that samples the sixth byte. Further bytes without `in_sof` produce no verdict.
- R4: The station address is matched with byte 0 (first on the wire) against `cfg_sta_hi[15:8]` and byte 1 against `cfg_sta_hi[7:0]`. Bytes 2, 3, 4 and 5 are matched against `cfg_sta_lo[31:24]`, `[23:16]`, `[15:8]` and `[7:0]` respectively. An exact match accepts the frame.
- R5: With `cfg_mode[3]` set, the address FF:FF:FF:FF:FF:FF is accepted.
- R6: With `cfg_mode[5]` set, every complete address is accepted.
- R7: The hash index is formed from a CRC register that starts at all ones and shifts each byte in LSB first. On each step it shifts right and XORs in 0xEDB88320 when the outgoing bit differs from the data bit. After all six bytes, with no final inversion, index bit (5-k) equals register bit k for k = 0..5.
- R8: An address whose byte 0 has bit 0 set is a group address. A group address is accepted when the hash bit it selects is set. Index bit 5 chooses `cfg_hash1` (1) or `cfg_hash0` (0), and index bits [4:0] pick the bit, so two all-ones hash words admit every group address.
- R9: With `cfg_mode[4]` set, a unicast address that misses the station address is also accepted when its hash bit is set. With `cfg_mode[4]` clear, the hash never admits a unicast address.
- R10: An address that meets none of the acceptance rules gets a verdict with `verdict_accept` low. This includes a broadcast address with `cfg_mode[3]` clear and no matching hash bit.
- R11: `in_eof` high while fewer than six bytes have been taken gives a verdict with `verdict_accept` low on the following cycle. `in_eof` while no address is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte qualifier |
| in_sof | input | 1 | Marks the first byte of a frame (with in_valid) |
| in_eof | input | 1 | Frame has ended |
| in_data | input | 8 | Received byte |
| cfg_mode | input | 3 (bits 5:3) | [3] broadcast enable, [4] individual hash, [5] promiscuous |
| cfg_sta_lo | input | 32 | Station address bytes 2..5 |
| cfg_sta_hi | input | 16 | Station address bytes 0..1 |
| cfg_hash0 | input | HASH_REG_W (32) | Hash bins 0..31 |
| cfg_hash1 | input | HASH_REG_W (32) | Hash bins 32..63 |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| verdict_accept | output | 1 | Frame accepted (meaningful with verdict_valid) |

## Verification
The assertions assume three things about the inputs:

- `in_sof` only accompanies `in_valid`;
- `in_eof` never coincides with `in_sof`;
- the configuration fields hold still while an address is being received, because the promiscuous, broadcast and station checks compare the cycle-of-completion configuration against the verdict one cycle later.

The stimulus changes configuration only between frames, while `in_valid` is low, and it raises `in_eof` only on cycles without a start marker. Hash bins are chosen by computing each address's index in the bench from the CRC rule, so that a single set bit either hits or misses on purpose.

// File: rtl/adf_pkg.sv
package adf_pkg;

  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned ADDR_W     = ADDR_BYTES * 8;
  localparam logic [31:0] CRC_INIT   = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY_R = 32'hEDB8_8320;

  typedef struct packed {
    logic promisc;
    logic hash_ind;
    logic bcast_en;
  } mode_t;

  // One byte through the reflected CRC-32 register, LSB of the byte first.
  function automatic logic [31:0] crc_step_byte(input logic [31:0] c_in,
                                                input logic [7:0]  d);
    logic [31:0] c;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ CRC_POLY_R;
      else             c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/adf_addr_track.sv
module adf_addr_track #(
  parameter int unsigned NBYTES = 6,
  localparam int unsigned AW    = NBYTES * 8,
  localparam int unsigned CNT_W = $clog2(NBYTES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic [7:0]    in_data,
  output logic          take_first,
  output logic          take_next,
  output logic          last_byte,
  output logic          abort,
  output logic [AW-1:0] addr_full
);

  logic [CNT_W-1:0] cnt_q;
  logic             active;
  logic             wr_en;
  logic [CNT_W-1:0] wr_idx;
  logic [7:0]       addr_q [NBYTES-1];

  assign active     = (cnt_q != '0);
  assign take_first = in_valid & in_sof;
  assign take_next  = in_valid & ~in_sof & active;
  assign last_byte  = take_next & (cnt_q == CNT_W'(NBYTES - 1));
  assign abort      = in_eof & active & ~last_byte;
  assign wr_en      = take_first | take_next;
  assign wr_idx     = take_first ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst)             cnt_q <= '0;
    else if (take_first) cnt_q <= CNT_W'(1);
    else if (last_byte)  cnt_q <= '0;
    else if (abort)      cnt_q <= '0;
    else if (take_next)  cnt_q <= cnt_q + CNT_W'(1);
  end

  // Held address bytes; the final byte is used live from in_data.
  for (genvar k = 0; k < NBYTES - 1; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == CNT_W'(k))) addr_q[k] <= in_data;
    end
    assign addr_full[AW-1-8*k -: 8] = addr_q[k];
  end
  assign addr_full[7:0] = in_data;

  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(NBYTES - 1));

  a_r2_sof_restarts: assert property (@(posedge clk) disable iff (rst)
    take_first |=> (cnt_q == CNT_W'(1)));

  a_r11_abort_idles: assert property (@(posedge clk) disable iff (rst)
    (abort && !take_first) |=> (cnt_q == '0));

endmodule

// File: rtl/adf_crc_unit.sv
module adf_crc_unit
  import adf_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        take_first,
  input  logic        take_next,
  input  logic [7:0]  in_data,
  output logic [31:0] crc_after
);

  logic [31:0] crc_q;
  logic [31:0] crc_base;

  assign crc_base  = take_first ? CRC_INIT : crc_q;
  assign crc_after = crc_step_byte(crc_base, in_data);

  always_ff @(posedge clk) begin
    if (rst)                          crc_q <= CRC_INIT;
    else if (take_first || take_next) crc_q <= crc_after;
  end

endmodule

// File: rtl/adf_match.sv
module adf_match
  import adf_pkg::*;
#(
  parameter int unsigned IDX_W  = 6,
  localparam int unsigned REG_W = 2 ** (IDX_W - 1)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [IDX_W-1:0]  crc_low,
  input  logic [ADDR_W-1:0] station,
  input  mode_t             mode,
  input  logic [REG_W-1:0]  hash0,
  input  logic [REG_W-1:0]  hash1,
  output logic              hit
);

  logic [IDX_W-1:0] idx;
  logic [REG_W-1:0] hash_word;
  logic             hash_bit;
  logic             group_addr;
  logic             bcast_addr;
  logic             sta_hit;

  // Index is the bit-reversed low end of the reflected CRC register.
  for (genvar k = 0; k < IDX_W; k++) begin : g_idx
    assign idx[IDX_W-1-k] = crc_low[k];
  end

  assign hash_word  = idx[IDX_W-1] ? hash1 : hash0;
  assign hash_bit   = hash_word[idx[IDX_W-2:0]];
  assign group_addr = addr[ADDR_W-8];
  assign bcast_addr = &addr;
  assign sta_hit    = (addr == station);

  assign hit = mode.promisc
             | sta_hit
             | (bcast_addr & mode.bcast_en)
             | (hash_bit & (group_addr | mode.hash_ind));

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import adf_pkg::*;
#(
  parameter int unsigned HASH_IDX_W = 6,
  localparam int unsigned HASH_REG_W = 2 ** (HASH_IDX_W - 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic                  in_sof,
  input  logic                  in_eof,
  input  logic [7:0]            in_data,
  input  logic [5:3]            cfg_mode,
  input  logic [31:0]           cfg_sta_lo,
  input  logic [15:0]           cfg_sta_hi,
  input  logic [HASH_REG_W-1:0] cfg_hash0,
  input  logic [HASH_REG_W-1:0] cfg_hash1,
  output logic                  verdict_valid,
  output logic                  verdict_accept
);

  logic              take_first, take_next, last_byte, abort;
  logic [ADDR_W-1:0] addr_full;
  logic [ADDR_W-1:0] station;
  logic [31:0]       crc_after;
  logic              hit;
  mode_t             mode;

  assign station       = {cfg_sta_hi, cfg_sta_lo};
  assign mode.promisc  = cfg_mode[5];
  assign mode.hash_ind = cfg_mode[4];
  assign mode.bcast_en = cfg_mode[3];

  adf_addr_track #(.NBYTES(ADDR_BYTES)) u_track (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .take_first(take_first), .take_next(take_next),
    .last_byte(last_byte), .abort(abort), .addr_full(addr_full)
  );

  adf_crc_unit u_crc (
    .clk(clk), .rst(rst),
    .take_first(take_first), .take_next(take_next),
    .in_data(in_data), .crc_after(crc_after)
  );

  adf_match #(.IDX_W(HASH_IDX_W)) u_match (
    .addr(addr_full), .crc_low(crc_after[HASH_IDX_W-1:0]),
    .station(station), .mode(mode),
    .hash0(cfg_hash0), .hash1(cfg_hash1), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      verdict_valid  <= 1'b0;
      verdict_accept <= 1'b0;
    end else begin
      verdict_valid  <= last_byte | abort;
      verdict_accept <= last_byte & hit;
    end
  end

  a_r1_accept_with_valid: assert property (@(posedge clk) disable iff (rst)
    verdict_accept |-> verdict_valid);

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    verdict_valid |=> !verdict_valid);

  a_r4_station_accept: assert property (@(posedge clk) disable iff (rst)
    (last_byte && addr_full == station) |=> verdict_accept);

  a_r5_bcast_accept: assert property (@(posedge clk) disable iff (rst)
    (last_byte && (&addr_full) && cfg_mode[3]) |=> verdict_accept);

  a_r6_promisc_accept: assert property (@(posedge clk) disable iff (rst)
    (last_byte && cfg_mode[5]) |=> (verdict_valid && verdict_accept));

  a_r11_runt_reject: assert property (@(posedge clk) disable iff (rst)
    (abort && !last_byte) |=> (verdict_valid && !verdict_accept));

endmodule

// File: tb/rx_dest_filter_tb_top.sv
module rx_dest_filter_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = '0;
  logic [5:3]  cfg_mode = '0;
  logic [31:0] cfg_sta_lo = '0;
  logic [15:0] cfg_sta_hi = '0;
  logic [31:0] cfg_hash0 = '0, cfg_hash1 = '0;
  logic        verdict_valid, verdict_accept;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  rx_dest_filter dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .cfg_mode(cfg_mode), .cfg_sta_lo(cfg_sta_lo),
    .cfg_sta_hi(cfg_sta_hi), .cfg_hash0(cfg_hash0), .cfg_hash1(cfg_hash1),
    .verdict_valid(verdict_valid), .verdict_accept(verdict_accept)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Hash index per R7, computed bit by bit
  function automatic logic [5:0] tb_hash_idx(input logic [47:0] a);
    logic [31:0] r;
    logic [7:0]  b;
    logic        fb;
    logic [5:0]  ix;
    r = 32'hFFFF_FFFF;
    for (int n = 0; n < 6; n++) begin
      b = a[47-8*n -: 8];
      for (int i = 0; i < 8; i++) begin
        fb = r[0] ^ b[i];
        r  = {1'b0, r[31:1]};
        if (fb) r = r ^ 32'hEDB8_8320;
      end
    end
    for (int k = 0; k < 6; k++) ix[5-k] = r[k];
    return ix;
  endfunction

  task automatic set_bin(input logic [5:0] ix);
    cfg_hash0 = '0;
    cfg_hash1 = '0;
    if (ix[5]) cfg_hash1[ix[4:0]] = 1'b1;
    else       cfg_hash0[ix[4:0]] = 1'b1;
  endtask

  // Drives n bytes of a (byte 0 first), returns at the negedge after the last one.
  task automatic send_bytes(input logic [47:0] a, input int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_data  = a[47-8*i -: 8];
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_sof   = 1'b0;
  endtask

  task automatic run_addr(input logic [47:0] a, input bit exp_acc, input string req);
    send_bytes(a, 6);
    check(verdict_valid === 1'b1, {req, " verdict strobe"}, 32'(verdict_valid), 1);
    check(verdict_accept === exp_acc, {req, " accept"}, 32'(verdict_accept), 32'(exp_acc));
    @(negedge clk);
    check(verdict_valid === 1'b0, "R3 pulse one cycle", 32'(verdict_valid), 0);
  endtask

  task automatic t_reset;
    check(verdict_valid === 1'b0 && verdict_accept === 1'b0, "R1 reset state",
          {30'd0, verdict_valid, verdict_accept}, 0);
  endtask

  task automatic t_station;
    cfg_mode = '0; cfg_sta_hi = 16'h0211; cfg_sta_lo = 32'h2233_4455;
    cfg_hash0 = '0; cfg_hash1 = '0;
    run_addr(48'h0211_2233_4455, 1'b1, "R4 station match");
    run_addr(48'h1102_2233_4455, 1'b0, "R4 byte order swapped");
    run_addr(48'h0211_2233_4456, 1'b0, "R10 unicast miss");
  endtask

  task automatic t_bcast;
    cfg_hash0 = '0; cfg_hash1 = '0;
    cfg_mode = 3'b001;
    run_addr(48'hFFFF_FFFF_FFFF, 1'b1, "R5 broadcast enabled");
    cfg_mode = 3'b000;
    run_addr(48'hFFFF_FFFF_FFFF, 1'b0, "R10 broadcast disabled");
  endtask

  task automatic t_promisc;
    cfg_mode = 3'b100; cfg_hash0 = '0; cfg_hash1 = '0;
    run_addr(48'h0A5C_9E31_77D2, 1'b1, "R6 promiscuous unicast");
    run_addr(48'h4400_0000_0001, 1'b1, "R6 promiscuous other");
    cfg_mode = 3'b000;
  endtask

  task automatic t_hash;
    logic [47:0] ga;
    logic [5:0]  ix;
    ga = 48'h0100_5E00_0001;
    ix = tb_hash_idx(ga);
    cfg_mode = '0;
    set_bin(ix);
    run_addr(ga, 1'b1, "R7 R8 hash bin hit");
    cfg_hash0 = ~cfg_hash0; cfg_hash1 = ~cfg_hash1;
    run_addr(ga, 1'b0, "R8 every other bin set");
    set_bin(ix ^ 6'h20);
    run_addr(ga, 1'b0, "R8 wrong hash register");
    cfg_hash0 = '1; cfg_hash1 = '1;
    run_addr(48'h3333_0000_0001, 1'b1, "R8 all bins group");
    run_addr(48'h0211_2233_4457, 1'b0, "R9 unicast ignores hash");
  endtask

  task automatic t_indiv;
    logic [47:0] ua;
    ua = 48'h02AA_BBCC_DDEE;
    set_bin(tb_hash_idx(ua));
    cfg_mode = 3'b000;
    run_addr(ua, 1'b0, "R9 individual hash off");
    cfg_mode = 3'b010;
    run_addr(ua, 1'b1, "R9 individual hash on");
    cfg_mode = 3'b000;
  endtask

  task automatic t_runt;
    cfg_mode = 3'b100;
    send_bytes(48'h0211_2233_4455, 3);
    check(verdict_valid === 1'b0, "R1 no verdict mid address", 32'(verdict_valid), 0);
    in_eof = 1'b1;
    @(negedge clk);
    in_eof = 1'b0;
    check(verdict_valid === 1'b1 && verdict_accept === 1'b0, "R11 runt rejected",
          {30'd0, verdict_valid, verdict_accept}, 32'h2);
    @(negedge clk);
    cfg_mode = 3'b000;
  endtask

  task automatic t_trailing;
    bit seen;
    cfg_mode = 3'b100;
    run_addr(48'h0211_2233_4455, 1'b1, "R3 frame before trailer");
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      in_valid = 1'b1; in_data = 8'(i * 37);
      @(negedge clk);
      if (verdict_valid) seen = 1;
    end
    in_valid = 1'b0;
    @(negedge clk);
    if (verdict_valid) seen = 1;
    check(!seen, "R3 trailing bytes ignored", 32'(seen), 0);
    in_eof = 1'b1;
    @(negedge clk);
    in_eof = 1'b0;
    @(negedge clk);
    check(verdict_valid === 1'b0, "R11 eof while idle", 32'(verdict_valid), 0);
    cfg_mode = 3'b000;
  endtask

  task automatic t_restart;
    cfg_mode = 3'b000; cfg_sta_hi = 16'h0211; cfg_sta_lo = 32'h2233_4455;
    cfg_hash0 = '0; cfg_hash1 = '0;
    send_bytes(48'h0999_8877_6655, 4);
    check(verdict_valid === 1'b0, "R2 abandoned address silent", 32'(verdict_valid), 0);
    run_addr(48'h0211_2233_4455, 1'b1, "R2 restart on sof");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_station();
    t_bcast();
    t_promisc();
    t_hash();
    t_indiv();
    t_runt();
    t_trailing();
    t_restart();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule